// File: doc/BRIEF.md
# Fractional Clock Divider with Staged Update

This block turns a fast input clock into a stream of single-cycle enable pulses whose average spacing equals a programmable fractional divisor. The divisor is held in a bit field inside a 32-bit control word: a field value `v` with `F` fractional bits gives a divisor of `1 + v / 2^F`. The smallest divisor is exactly 1, which happens when `v = 0`. The largest is `1 + (2^W - 1) / 2^F`, which happens when the `W`-bit field is all ones. The fraction is realised by a phase accumulator. Each output period is either the whole part of the divisor or one input cycle longer, so the long-run rate matches the programmed value.

Software changes the divisor in two steps. It first writes the field, which only fills a shadow copy. It then sets a self-clearing trigger bit, which stages the shadow value and reads back as 1 until the generator starts using the staged value. The switch happens only at the end of an output period, so no shortened period is produced. Writes are bit-masked, so updating the field never disturbs the other bits of the control word. A build-time option makes the divisor a constant: the field then cannot be written and the trigger never goes busy.

Top module: `frac_clk_divider`

## Requirements
- R1: With active field value v, output pulses repeat every 1 + v/2^F input cycles on average. v = 0 gives a pulse on every cycle, and a value with zero fractional bits gives exactly evenly spaced pulses.
- R2: An all-ones field (0xFF with W=8, F=4) gives intervals of 16 or 17 cycles, and any 16 consecutive intervals total exactly 271 cycles.
- R3: A write changes only the control-word bits whose mask bit is 1. The field is at bits [FIELD_SHIFT+FIELD_W-1:FIELD_SHIFT] (default [15:8]) and the trigger is at bit TRIG_POS (default 0). The remaining bits are plain read/write storage.
- R4: A field write without the trigger changes only the readback value. The output spacing keeps the previous active value.
- R5: Writing 1 to the trigger bit makes it read 1 from the next cycle onward. It returns to 0 by itself in the same cycle that the staged value becomes active. Writing 0 to the trigger bit has no effect.
- R6: With FIXED_DIV set, the field always reads FIXED_FIELD, writes to it are ignored, the trigger bit never reads 1, and the pulse spacing always follows FIXED_FIELD.
- R7: A new divisor takes effect only at a period boundary. The interval during which the trigger is written keeps the old length.
- R8: The fractional part is spread by the accumulator. For field 0x18 (divisor 2.5), every interval is 2 or 3 cycles, and any 10 consecutive intervals total 25 cycles.
- R9: While reset is active, the control word reads 0 and no pulse is produced. After reset the active field is 0 and no update is pending.
- R10: While the trigger is busy, field writes update only the shadow, and a new trigger request is ignored. The value staged at the accepted trigger is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 32 | Per-bit write enable |
| rd_data_o | output | 32 | Control word readback: shadow field, trigger busy, spare bits |
| pulse_o | output | 1 | Divided output enable, one cycle per period |

## Verification
The assertions rely on a few properties of the inputs. Write strobes are single-cycle. The field and trigger positions do not overlap. The trigger bit is held low in the mask whenever only the field is meant to change. The bench drives every write on the falling edge as a one-cycle strobe with an explicit mask. It issues the write-while-busy sequence right after an observed pulse, so that the old period is long enough for the trigger to still be busy. The fractional cases are checked over whole accumulator cycles, so the expected totals do not depend on the accumulator phase left behind by earlier tests.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned CTRL_W = 32;

  function automatic logic [CTRL_W-1:0] span_mask(input int unsigned lsb, input int unsigned width);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < CTRL_W; i++)
      if (i >= lsb && i < lsb + width) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int unsigned FIELD_SHIFT = 8,
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned TRIG_POS    = 0,
  parameter bit          FIXED_DIV   = 1'b0,
  parameter int unsigned FIXED_FIELD = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CTRL_W-1:0]  wr_data_i,
  input  logic [CTRL_W-1:0]  wr_mask_i,
  input  logic               boundary_i,
  output logic [CTRL_W-1:0]  rd_data_o,
  output logic               busy_o,
  output logic [FIELD_W-1:0] staged_o
);
  localparam logic [CTRL_W-1:0]  FMASK   = span_mask(FIELD_SHIFT, FIELD_W);
  localparam logic [CTRL_W-1:0]  TMASK   = CTRL_W'(1) << TRIG_POS;
  localparam logic [CTRL_W-1:0]  SPARE   = ~(FMASK | TMASK);
  localparam logic [FIELD_W-1:0] FIX_VAL = FIELD_W'(FIXED_FIELD);

  logic [CTRL_W-1:0]  spare_q;
  logic [FIELD_W-1:0] shadow;
  logic               trig_req;

  assign trig_req = wr_en_i & wr_mask_i[TRIG_POS] & wr_data_i[TRIG_POS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spare_q <= '0;
    else if (wr_en_i)
      spare_q <= (spare_q & ~(wr_mask_i & SPARE)) | (wr_data_i & wr_mask_i & SPARE);
  end

  generate
    if (FIXED_DIV) begin : g_fixed
      assign shadow   = FIX_VAL;
      assign busy_o   = 1'b0;
      assign staged_o = FIX_VAL;

      assert_fixed_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[FIELD_SHIFT +: FIELD_W] == FIX_VAL) && !rd_data_o[TRIG_POS]);
    end else begin : g_prog
      logic [FIELD_W-1:0] shadow_q, shadow_d, staged_q, fmask;
      logic               busy_q;

      assign fmask    = wr_en_i ? wr_mask_i[FIELD_SHIFT +: FIELD_W] : '0;
      assign shadow_d = (shadow_q & ~fmask) | (wr_data_i[FIELD_SHIFT +: FIELD_W] & fmask);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shadow_q <= '0;
          staged_q <= '0;
          busy_q   <= 1'b0;
        end else begin
          shadow_q <= shadow_d;
          if (busy_q) begin
            if (boundary_i) busy_q <= 1'b0;
          end else if (trig_req) begin
            busy_q   <= 1'b1;
            staged_q <= shadow_d;
          end
        end
      end

      assign shadow   = shadow_q;
      assign busy_o   = busy_q;
      assign staged_o = staged_q;

      // busy releases only when the generator passes a period boundary
      assert_busy_clears_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_q) |-> $past(boundary_i));
      assert_staged_frozen_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_q |=> $stable(staged_q));
    end
  endgenerate

  always_comb begin
    rd_data_o = spare_q & SPARE;
    rd_data_o[FIELD_SHIFT +: FIELD_W] = shadow;
    rd_data_o[TRIG_POS] = busy_o;
  end

  assert_spare_untouched_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && |(wr_mask_i & SPARE)) |=> $stable(rd_data_o & SPARE));
endmodule

// File: rtl/frac_div_gen.sv
module frac_div_gen #(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned FRAC_W      = 4,
  parameter int unsigned RESET_FIELD = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [FIELD_W-1:0] staged_i,
  output logic               boundary_o,
  output logic               pulse_o,
  output logic [FIELD_W-1:0] active_o
);
  localparam int unsigned INT_W = FIELD_W - FRAC_W;
  localparam int unsigned CNT_W = INT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << INT_W;

  logic [CNT_W-1:0]   cnt_q, len_m1;
  logic [FRAC_W-1:0]  acc_q;
  logic [FRAC_W:0]    sum;
  logic [FIELD_W-1:0] active_q, next_field;
  logic               pulse_q;

  assign boundary_o = (cnt_q == '0);
  assign next_field = busy_i ? staged_i : active_q;
  assign sum        = {1'b0, acc_q} + {1'b0, next_field[FRAC_W-1:0]};
  // carry out of the accumulator stretches this period by one cycle
  assign len_m1     = CNT_W'(next_field[FIELD_W-1:FRAC_W]) + CNT_W'(sum[FRAC_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      active_q <= FIELD_W'(RESET_FIELD);
      pulse_q  <= 1'b0;
    end else if (boundary_o) begin
      cnt_q    <= len_m1;
      acc_q    <= sum[FRAC_W-1:0];
      active_q <= next_field;
      pulse_q  <= 1'b1;
    end else begin
      cnt_q    <= cnt_q - 1'b1;
      pulse_q  <= 1'b0;
    end
  end

  assign pulse_o  = pulse_q;
  assign active_o = active_q;

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_switch_on_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_o |=> $stable(active_q));
endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
  import frac_div_pkg::*;
#(
  parameter int unsigned FIELD_SHIFT = 8,
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned FRAC_W      = 4,
  parameter int unsigned TRIG_POS    = 0,
  parameter bit          FIXED_DIV   = 1'b0,
  parameter int unsigned FIXED_FIELD = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic [31:0] wr_mask_i,
  output logic [31:0] rd_data_o,
  output logic        pulse_o
);
  localparam int unsigned RESET_FIELD = FIXED_DIV ? FIXED_FIELD : 0;

  logic               busy, boundary;
  logic [FIELD_W-1:0] staged, active;

  frac_div_ctrl #(
    .FIELD_SHIFT(FIELD_SHIFT), .FIELD_W(FIELD_W), .TRIG_POS(TRIG_POS),
    .FIXED_DIV(FIXED_DIV), .FIXED_FIELD(FIXED_FIELD)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .wr_mask_i(wr_mask_i), .boundary_i(boundary), .rd_data_o(rd_data_o),
    .busy_o(busy), .staged_o(staged)
  );

  frac_div_gen #(
    .FIELD_W(FIELD_W), .FRAC_W(FRAC_W), .RESET_FIELD(RESET_FIELD)
  ) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .staged_i(staged),
    .boundary_o(boundary), .pulse_o(pulse_o), .active_o(active)
  );

  assert_apply_staged_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (active == $past(staged)));
  assert_active_needs_trigger_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active) |-> $past(busy));
endmodule

// File: tb/frac_clk_divider_test.sv
module frac_clk_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FW_MASK = 32'h0000_FF01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0, wr_mask = '0;
  logic [31:0] rd_data, rd_fix;
  logic        pulse, pulse_fix;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_clk_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_mask_i(wr_mask), .rd_data_o(rd_data), .pulse_o(pulse));

  frac_clk_divider #(.FIXED_DIV(1'b1), .FIXED_FIELD(8'h20)) uut_fix (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_mask_i(wr_mask), .rd_data_o(rd_fix), .pulse_o(pulse_fix));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [31:0] m);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic get_interval(input bit fx, output int n);
    int guard = 0;
    while (!(fx ? pulse_fix : pulse) && guard < 1000) begin @(negedge clk); guard++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!(fx ? pulse_fix : pulse) && n < 1000);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (rd_data[0] && guard < 1000) begin @(negedge clk); guard++; end
    check(!rd_data[0], "R5 busy self-clears", rd_data[0], 0);
  endtask

  task automatic apply(input logic [7:0] f);
    wr({16'h0, f, 8'h01}, FW_MASK);
    check(rd_data[0], "R5 busy reads 1 after trigger", rd_data[0], 1);
    wait_idle();
  endtask

  task automatic t_reset();
    check(rd_data == 32'h0 && !pulse, "R9 reset state", {pulse, rd_data[30:0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 32'h0, "R9 no pending update", rd_data, 0);
  endtask

  task automatic t_unit();
    int n;
    for (int i = 0; i < 4; i++) begin
      get_interval(1'b0, n);
      check(n == 1, "R1 field 0 pulses every cycle", n, 1);
    end
  endtask

  task automatic t_masked_write();
    int n;
    wr(32'hDEAD_00F0, ~FW_MASK);
    check(rd_data == 32'hDEAD_00F0, "R3 spare bits written", rd_data, 32'hDEAD_00F0);
    wr(32'hFFFF_5AFF, 32'h0000_FF00);
    check(rd_data == 32'hDEAD_5AF0, "R3 field-only write keeps others", rd_data, 32'hDEAD_5AF0);
    wr(32'h0, 32'h0000_0001);
    check(rd_data[0] == 1'b0, "R5 writing 0 to trigger is a no-op", rd_data[0], 0);
    for (int i = 0; i < 3; i++) begin
      get_interval(1'b0, n);
      check(n == 1, "R4 pending field not yet active", n, 1);
    end
  endtask

  task automatic t_frac_5a();
    int n, sum = 0;
    wr(32'h1, 32'h1);
    check(rd_data[0], "R5 busy after trigger", rd_data[0], 1);
    wait_idle();
    for (int i = 0; i < 8; i++) begin get_interval(1'b0, n); sum += n; end
    check(sum == 53, "R1 field 0x5A over 8 periods", sum, 53);
    check(rd_data == 32'hDEAD_5AF0, "R3 readback after trigger", rd_data, 32'hDEAD_5AF0);
  endtask

  task automatic t_busy_write();
    int n;
    get_interval(1'b0, n);
    wr(32'h0000_5001, FW_MASK);
    wr(32'h0000_1001, FW_MASK);
    check(rd_data[15:8] == 8'h10 && rd_data[0], "R10 shadow updated while busy",
          rd_data[15:0], 16'h1001);
    wait_idle();
    for (int i = 0; i < 3; i++) begin
      get_interval(1'b0, n);
      check(n == 6, "R10 staged value active, not later write", n, 6);
    end
    wr(32'h1, 32'h1);
    wait_idle();
    get_interval(1'b0, n);
    check(n == 2, "R10 later value needs new trigger", n, 2);
  endtask

  task automatic t_boundary_switch();
    int n;
    apply(8'h50);
    get_interval(1'b0, n);
    check(n == 6, "R1 integer divisor 6", n, 6);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 2) begin wr_en = 1'b1; wr_data = 32'h0000_1001; wr_mask = FW_MASK; end
      if (n == 3) begin wr_en = 1'b0; wr_data = '0; wr_mask = '0; end
    end while (!pulse && n < 1000);
    check(n == 6, "R7 interval holding trigger keeps old length", n, 6);
    get_interval(1'b0, n);
    check(n == 2, "R7 next interval uses new divisor", n, 2);
  endtask

  task automatic t_frac_half();
    int n, sum = 0;
    bit ok = 1'b1;
    apply(8'h18);
    for (int i = 0; i < 10; i++) begin
      get_interval(1'b0, n); sum += n;
      if (n != 2 && n != 3) ok = 1'b0;
    end
    check(ok, "R8 intervals are 2 or 3", ok, 1);
    check(sum == 25, "R8 ten periods total 25", sum, 25);
  endtask

  task automatic t_max();
    int n, sum = 0;
    bit ok = 1'b1;
    apply(8'hFF);
    for (int i = 0; i < 16; i++) begin
      get_interval(1'b0, n); sum += n;
      if (n != 16 && n != 17) ok = 1'b0;
    end
    check(ok, "R2 max intervals 16 or 17", ok, 1);
    check(sum == 271, "R2 sixteen periods total 271", sum, 271);
  endtask

  task automatic t_fixed();
    int n;
    check(rd_fix[15:8] == 8'h20, "R6 fixed field reads constant", rd_fix[15:8], 8'h20);
    wr(32'h0000_7701, FW_MASK);
    check(rd_fix[15:8] == 8'h20 && !rd_fix[0], "R6 write and trigger ignored",
          rd_fix[15:0], 16'h2000);
    for (int i = 0; i < 4; i++) begin
      get_interval(1'b1, n);
      check(n == 3, "R6 fixed divisor 3", n, 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_unit();
    t_masked_write();
    t_frac_5a();
    t_busy_write();
    t_boundary_switch();
    t_frac_half();
    t_max();
    t_fixed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule